// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a direct-mapped data cache paired with a small fully associative buffer that catches lines the cache throws out. A CPU issues one word read or write at a time. A hit in the cache answers in the next cycle. When the cache misses, the controller first searches the buffer. On a buffer hit, the wanted line and the line now sitting in its cache set trade places in one step, and the answer comes one cycle later than a cache hit. No lower-level traffic takes place.

Only when both miss does the block ask the lower memory level for the line. The line pushed out of the cache set then enters the buffer in first-in, first-out order. If the buffer entry it overwrites holds modified data, that entry is written to the lower level before the refill read is issued. The default shape is a 4 KB cache of 16-byte lines, 32-bit byte addresses, 32-bit words and four buffer entries.

Top module: `victimCache`

## Requirements
- R1: After reset, `reqReady` is 1, `rspValid` and `memReq` are 0, and every cache line and buffer entry is empty, so the first access to any line goes to the lower level.
- R2: A request that hits the cache is accepted in the cycle `reqValid` and `reqReady` are both 1. `rspValid` is 1 in the next cycle with no lower-level request. A read returns the word at address bits [3:2]; a write stores `reqWdata` there and returns it.
- R3: A request that misses the cache but matches a buffer entry is answered with `rspValid` two cycles after acceptance, with no lower-level request and with the line's latest contents, including earlier writes.
- R4: On a buffer hit, the line displaced from the cache set moves into the freed buffer entry, so an immediate access to that displaced line is again a two-cycle buffer hit.
- R5: When both miss, the block issues a read with `memWrite` 0 and `memAddr` equal to address bits [31:4]. It takes the line from `memRdata` (word w in bits [32w+31:32w]) in the acknowledge cycle and raises `rspValid` in the following cycle.
- R6: A valid line displaced by a refill enters the buffer in insertion order. With four entries, the fifth insertion replaces the oldest one, which is then served from the lower level again.
- R7: A modified buffer entry that is about to be replaced is first written out with `memWrite` 1, `memAddr` set to its line address and `memWdata` set to its data. This happens before the refill read, so a later read of that line returns the written data.
- R8: While `memReq` is 1 and `memAck` is 0, `memReq`, `memWrite` and `memAddr` keep their values into the next cycle.
- R9: At most one buffer entry matches a line address, and a buffered line is never also valid in the cache. A response within two cycles therefore never involves the lower level, and any lower-level access gives a latency of at least three cycles.
- R10: Every read returns the value of the most recent write to that word, or the lower level's initial contents if the word was never written.
- R11: Between accepting a request that misses the cache and raising its response, `reqReady` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | CPU request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqWrite | input | 1 | 1 = word write, 0 = word read |
| reqAddr | input | 32 | Byte address of the word |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response word valid (one cycle) |
| rspData | output | 32 | Read word, or the stored word for a write |
| memReq | output | 1 | Lower-level request, held until acknowledged |
| memWrite | output | 1 | 1 = line writeback, 0 = line refill read |
| memAddr | output | 28 | Line address (byte address bits [31:4]) |
| memWdata | output | 128 | Writeback line data |
| memAck | input | 1 | One-cycle acknowledge of the pending lower-level request |
| memRdata | input | 128 | Refill line data, valid with `memAck` |

## Verification
The assertions assume the following about the inputs. `memAck` is a single-cycle pulse that comes only while `memReq` is 1. `memRdata` is valid in that cycle. A request stays on `reqValid` until it is accepted. The bench's lower-level model enforces all three: it acknowledges each request exactly once, after a random delay of one to three cycles. It presents the line data only together with the pulse. The CPU driver raises `reqValid` only while the block is idle and lowers it right after acceptance. Random addresses are confined to six tags over four sets, which forces frequent conflicts, swaps, FIFO drops and writebacks of modified lines.

// File: rtl/victimCachePkg.sv
package victimCachePkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROBE,
    ST_WBACK,
    ST_FILL
  } ctrlState_t;

  typedef struct packed {
    logic hit;      // cache hit: serve request now
    logic latch;    // capture missing request
    logic swap;     // buffer hit: exchange lines
    logic wbPhase;  // lower level is receiving a buffer entry
    logic wbDone;   // writeback acknowledged
    logic fill;     // refill line arrived
  } dpStrobe_t;

endpackage

// File: rtl/victimCacheCtrl.sv
module victimCacheCtrl
  import victimCachePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      cacheHit,
  input  logic      vbHit,
  input  logic      wbNeeded,
  input  logic      memAck,
  output logic      reqReady,
  output logic      memReq,
  output logic      memWrite,
  output dpStrobe_t strobe
);

  ctrlState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    reqReady  = 1'b0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          if (cacheHit) begin
            strobe.hit = 1'b1;
          end else begin
            strobe.latch = 1'b1;
            nextState    = ST_PROBE;
          end
        end
      end
      ST_PROBE: begin
        if (vbHit) begin
          strobe.swap = 1'b1;
          nextState   = ST_IDLE;
        end else if (wbNeeded) begin
          nextState = ST_WBACK;
        end else begin
          nextState = ST_FILL;
        end
      end
      ST_WBACK: begin
        memReq         = 1'b1;
        memWrite       = 1'b1;
        strobe.wbPhase = 1'b1;
        if (memAck) begin
          strobe.wbDone = 1'b1;
          nextState     = ST_FILL;
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.fill = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> !reqReady);

endmodule

// File: rtl/victimCacheDp.sv
module victimCacheDp
  import victimCachePkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int LINE_BYTES  = 16,
  parameter int CACHE_BYTES = 4096,
  parameter int VB_ENTRIES  = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  dpStrobe_t                              strobe,
  input  logic                                   reqWrite,
  input  logic [ADDR_W-1:0]                      reqAddr,
  input  logic [WORD_W-1:0]                      reqWdata,
  input  logic [LINE_BYTES*8-1:0]                memRdata,
  output logic                                   cacheHit,
  output logic                                   vbHit,
  output logic                                   wbNeeded,
  output logic                                   rspValid,
  output logic [WORD_W-1:0]                      rspData,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   memAddr,
  output logic [LINE_BYTES*8-1:0]                memWdata
);

  localparam int BOFF_W  = $clog2(WORD_W / 8);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int WSEL_W  = OFF_W - BOFF_W;
  localparam int SETS    = CACHE_BYTES / LINE_BYTES;
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int LINE_W  = LINE_BYTES * 8;
  localparam int VB_W    = (VB_ENTRIES > 1) ? $clog2(VB_ENTRIES) : 1;

  function automatic logic [LINE_W-1:0] mergeWord(input logic [LINE_W-1:0] ln,
                                                  input logic [WSEL_W-1:0] w,
                                                  input logic [WORD_W-1:0] d);
    logic [LINE_W-1:0] r;
    r = ln;
    r[w*WORD_W +: WORD_W] = d;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] pickWord(input logic [LINE_W-1:0] ln,
                                                 input logic [WSEL_W-1:0] w);
    return ln[w*WORD_W +: WORD_W];
  endfunction

  // cache storage
  logic [LINE_W-1:0] cData [SETS];
  logic [TAG_W-1:0]  cTag  [SETS];
  logic [SETS-1:0]   cValid, cDirty;

  // buffer storage
  logic [LINE_W-1:0]  vData [VB_ENTRIES];
  logic [LADDR_W-1:0] vAddr [VB_ENTRIES];
  logic [VB_ENTRIES-1:0] vValid, vDirty, vMatch;
  logic [VB_W-1:0] vPtr, vSel, vPtrNext;

  // latched missing request
  logic [ADDR_W-1:0] lAddr;
  logic              lWrite;
  logic [WORD_W-1:0] lWdata;

  logic [IDX_W-1:0]   inIdx, lIdx;
  logic [TAG_W-1:0]   inTag, lTag;
  logic [WSEL_W-1:0]  inWord, lWord;
  logic [LADDR_W-1:0] lLine, dispAddr;
  logic [LINE_W-1:0]  hitNew, swapNew, fillNew, dispLine;
  logic               dispValid, dispDirty;
  logic               unusedBits;

  assign inIdx  = reqAddr[OFF_W +: IDX_W];
  assign inTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign inWord = reqAddr[BOFF_W +: WSEL_W];
  assign lIdx   = lAddr[OFF_W +: IDX_W];
  assign lTag   = lAddr[ADDR_W-1 -: TAG_W];
  assign lWord  = lAddr[BOFF_W +: WSEL_W];
  assign lLine  = lAddr[ADDR_W-1 -: LADDR_W];
  assign unusedBits = ^{reqAddr[BOFF_W-1:0], lAddr[BOFF_W-1:0]};

  assign cacheHit = cValid[inIdx] && (cTag[inIdx] == inTag);

  // one comparator per buffer entry
  for (genvar e = 0; e < VB_ENTRIES; e++) begin : gCmp
    assign vMatch[e] = vValid[e] && (vAddr[e] == lLine);
  end

  assign vbHit = |vMatch;

  always_comb begin
    vSel = '0;
    for (int e = 0; e < VB_ENTRIES; e++) begin
      if (vMatch[e]) vSel = VB_W'(e);
    end
  end

  assign vPtrNext  = (vPtr == VB_W'(VB_ENTRIES - 1)) ? '0 : vPtr + 1'b1;
  assign dispAddr  = {cTag[lIdx], lIdx};
  assign dispLine  = cData[lIdx];
  assign dispValid = cValid[lIdx];
  assign dispDirty = cDirty[lIdx];
  assign wbNeeded  = dispValid && vValid[vPtr] && vDirty[vPtr];

  assign hitNew  = reqWrite ? mergeWord(cData[inIdx], inWord, reqWdata) : cData[inIdx];
  assign swapNew = lWrite ? mergeWord(vData[vSel], lWord, lWdata) : vData[vSel];
  assign fillNew = lWrite ? mergeWord(memRdata, lWord, lWdata) : memRdata;

  assign memAddr  = strobe.wbPhase ? vAddr[vPtr] : lLine;
  assign memWdata = vData[vPtr];

  // line payloads, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.hit && reqWrite) begin
      cData[inIdx]  <= hitNew;
      cDirty[inIdx] <= 1'b1;
    end
    if (strobe.swap) begin
      cData[lIdx]  <= swapNew;
      cTag[lIdx]   <= lTag;
      cDirty[lIdx] <= vDirty[vSel] | lWrite;
      vData[vSel]  <= dispLine;
      vAddr[vSel]  <= dispAddr;
    end
    if (strobe.fill) begin
      cData[lIdx]  <= fillNew;
      cTag[lIdx]   <= lTag;
      cDirty[lIdx] <= lWrite;
      if (dispValid) begin
        vData[vPtr] <= dispLine;
        vAddr[vPtr] <= dispAddr;
      end
    end
  end

  // valid bits, FIFO pointer, request latch, response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cValid   <= '0;
      vValid   <= '0;
      vDirty   <= '0;
      vPtr     <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
      lAddr    <= '0;
      lWrite   <= 1'b0;
      lWdata   <= '0;
    end else begin
      rspValid <= strobe.hit | strobe.swap | strobe.fill;
      if (strobe.latch) begin
        lAddr  <= reqAddr;
        lWrite <= reqWrite;
        lWdata <= reqWdata;
      end
      if (strobe.hit) rspData <= pickWord(hitNew, inWord);
      if (strobe.swap) begin
        cValid[lIdx] <= 1'b1;
        vValid[vSel] <= dispValid;
        vDirty[vSel] <= dispDirty;
        rspData      <= pickWord(swapNew, lWord);
      end
      if (strobe.wbDone) vDirty[vPtr] <= 1'b0;
      if (strobe.fill) begin
        cValid[lIdx] <= 1'b1;
        rspData      <= pickWord(fillNew, lWord);
        if (dispValid) begin
          vValid[vPtr] <= 1'b1;
          vDirty[vPtr] <= dispDirty;
          vPtr         <= vPtrNext;
        end
      end
    end
  end

  // R9
  vb_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(vMatch));

  // R9
  no_dual_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swap |-> !(cValid[lIdx] && (cTag[lIdx] == lTag)));

  // R7
  wb_before_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fill && dispValid) |-> !(vValid[vPtr] && vDirty[vPtr]));

endmodule

// File: rtl/victimCache.sv
module victimCache
  import victimCachePkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int LINE_BYTES  = 16,
  parameter int CACHE_BYTES = 4096,
  parameter int VB_ENTRIES  = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 reqValid,
  output logic                                 reqReady,
  input  logic                                 reqWrite,
  input  logic [ADDR_W-1:0]                    reqAddr,
  input  logic [WORD_W-1:0]                    reqWdata,
  output logic                                 rspValid,
  output logic [WORD_W-1:0]                    rspData,
  output logic                                 memReq,
  output logic                                 memWrite,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] memAddr,
  output logic [LINE_BYTES*8-1:0]              memWdata,
  input  logic                                 memAck,
  input  logic [LINE_BYTES*8-1:0]              memRdata
);

  dpStrobe_t strobe;
  logic cacheHit, vbHit, wbNeeded;

  victimCacheCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cacheHit (cacheHit),
    .vbHit    (vbHit),
    .wbNeeded (wbNeeded),
    .memAck   (memAck),
    .reqReady (reqReady),
    .memReq   (memReq),
    .memWrite (memWrite),
    .strobe   (strobe)
  );

  victimCacheDp #(
    .ADDR_W      (ADDR_W),
    .WORD_W      (WORD_W),
    .LINE_BYTES  (LINE_BYTES),
    .CACHE_BYTES (CACHE_BYTES),
    .VB_ENTRIES  (VB_ENTRIES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .memRdata  (memRdata),
    .cacheHit  (cacheHit),
    .vbHit     (vbHit),
    .wbNeeded  (wbNeeded),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .memAddr   (memAddr),
    .memWdata  (memWdata)
  );

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && (memWrite == $past(memWrite)) && $stable(memAddr)));

endmodule

// File: tb/victimCache_bench.sv
`timescale 1ns/1ps
module victimCache_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0]  reqAddr = '0, reqWdata = '0;
  logic         reqReady, rspValid;
  logic [31:0]  rspData;
  logic         memReq, memWrite;
  logic [27:0]  memAddr;
  logic [127:0] memWdata;
  logic         memAck = 1'b0;
  logic [127:0] memRdata = '0;

  always #2 clk = ~clk;

  victimCache u_victimCache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  int checks = 0, errors = 0, bufHits = 0, holdErr = 0;
  bit done = 0;

  logic [31:0]  refMem  [logic [29:0]];
  logic [127:0] lineMem [logic [27:0]];

  logic         memTouched = 0, wbSeen = 0;
  logic [27:0]  lastRdAddr = '0, wbAddr = '0;
  logic [127:0] wbData = '0;

  function automatic logic [31:0] initWord(input logic [29:0] wa);
    return {2'b00, wa} * 32'h9E37_79B1 + 32'h0135_7531;
  endfunction

  function automatic logic [31:0] refRead(input logic [29:0] wa);
    if (refMem.exists(wa)) return refMem[wa];
    return initWord(wa);
  endfunction

  function automatic logic [127:0] lineRead(input logic [27:0] la);
    logic [127:0] r;
    if (lineMem.exists(la)) return lineMem[la];
    for (int w = 0; w < 4; w++) r[w*32 +: 32] = initWord({la, 2'(w)});
    return r;
  endfunction

  function automatic logic [31:0] mk(input int tag, input int idx, input int word);
    return {20'(tag), 8'(idx), 2'(word), 2'b00};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // lower-level model: one acknowledge per request after 1..3 cycles
  initial begin
    bit busy = 0;
    int cnt = 0;
    logic [27:0] hAddr = '0;
    logic hWr = 0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
        busy = 0;
      end else if (memReq) begin
        memTouched = 1'b1;
        if (!busy) begin
          busy = 1; hAddr = memAddr; hWr = memWrite; cnt = 1 + int'($urandom % 3);
        end else if (memAddr !== hAddr || memWrite !== hWr) begin
          holdErr++;
        end
        cnt--;
        if (cnt == 0) begin
          memAck = 1'b1;
          if (hWr) begin
            lineMem[hAddr] = memWdata;
            wbSeen = 1'b1; wbAddr = hAddr; wbData = memWdata;
          end else begin
            memRdata = lineRead(hAddr);
            lastRdAddr = hAddr;
          end
        end
      end
    end
  end

  task automatic doTxn(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                       output int lat, output logic [31:0] data, output logic used,
                       output logic leak);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    memTouched = 1'b0;
    leak = 1'b0;
    lat = 0;
    forever begin
      @(negedge clk);
      reqValid = 1'b0;
      lat++;
      if (rspValid) break;
      if (reqReady) leak = 1'b1;
      if (lat > 300) break;
    end
    data = rspData;
    used = memTouched;
    if (wr) refMem[addr[31:2]] = wd;
  endtask

  task automatic finishRun();
    if (holdErr != 0) begin
      checks++; errors++;
      $display("FAIL R8 actual %0d expected 0 hold violations", holdErr);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    int lat;
    logic [31:0] d, a, b, wd;
    logic used, leak, wr;
    a = mk(1, 1, 0);
    b = mk(2, 1, 0);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reqReady", reqReady, 1);
    chk("R1 rspValid", rspValid, 0);
    chk("R1 memReq", memReq, 0);

    // R5 cold miss
    doTxn(0, a, 0, lat, d, used, leak);
    chk("R1 R5 cold miss uses memory", used, 1);
    chk("R5 refill address", lastRdAddr, a[31:4]);
    chk("R5 latency above two", lat > 2, 1);
    chk("R10 cold data", d, refRead(a[31:2]));
    chk("R11 ready low while busy", leak, 0);

    // R2 hit read, hit write
    doTxn(0, a, 0, lat, d, used, leak);
    chk("R2 hit latency", lat, 1);
    chk("R2 hit no memory", used, 0);
    doTxn(1, a + 8, 32'hDEAD_BEEF, lat, d, used, leak);
    chk("R2 write hit latency", lat, 1);
    chk("R2 write returns word", d, 32'hDEAD_BEEF);
    doTxn(0, a + 8, 0, lat, d, used, leak);
    chk("R10 read after write", d, 32'hDEAD_BEEF);

    // conflict in set 1, then buffer hits
    doTxn(0, b, 0, lat, d, used, leak);
    chk("R5 conflict miss uses memory", used, 1);
    chk("R11 ready low on conflict miss", leak, 0);
    doTxn(0, a + 8, 0, lat, d, used, leak);
    chk("R3 buffer hit latency", lat, 2);
    chk("R3 buffer hit no memory", used, 0);
    chk("R3 buffer hit keeps write", d, 32'hDEAD_BEEF);
    doTxn(0, b, 0, lat, d, used, leak);
    chk("R4 displaced line buffered", lat, 2);
    chk("R4 displaced line data", d, refRead(b[31:2]));

    // fill the FIFO: A (modified) is oldest
    for (int t = 3; t <= 5; t++) doTxn(0, mk(t, 1, 0), 0, lat, d, used, leak);
    wbSeen = 1'b0;
    doTxn(0, mk(6, 1, 0), 0, lat, d, used, leak);
    chk("R7 writeback issued", wbSeen, 1);
    chk("R7 writeback address", wbAddr, a[31:4]);
    chk("R7 writeback data", wbData[95:64], 32'hDEAD_BEEF);
    doTxn(0, b, 0, lat, d, used, leak);
    chk("R6 younger entry still buffered", lat, 2);
    doTxn(0, a + 8, 0, lat, d, used, leak);
    chk("R6 oldest entry dropped", used, 1);
    chk("R7 R10 data after writeback", d, 32'hDEAD_BEEF);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      wr = ($urandom % 10) < 3;
      a = mk(1 + int'($urandom % 6), int'($urandom % 4), int'($urandom % 4));
      wd = $urandom;
      doTxn(wr, a, wd, lat, d, used, leak);
      if (lat == 2 && !used) bufHits++;
      chk("R9 latency vs lower-level use", (lat > 2), used);
      chk("R11 ready low during miss", leak, 0);
      if (wr) chk("R2 write response", d, wd);
      else    chk("R10 random read", d, refRead(a[31:2]));
    end
    chk("R3 buffer hits occurred", bufHits > 0, 1);

    if (!done) begin
      done = 1;
      finishRun();
    end
  end

endmodule